// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the combinational arithmetic and logic stage of a small RISC controller core. In one cycle it combines a first operand with either a second register operand or an immediate byte. It returns the result byte, a write-enable telling the register file whether to store that result, and the complete next value of the six status flags.

Each operation class touches its own subset of flags. Flags outside that subset pass through from the incoming flag vector unchanged. The block produces a half-carry flag from the nibble boundary and a signed-test flag from the negative and overflow flags. The carry-chained subtract and compare forms keep the zero flag across bytes, so multi-byte comparisons and subtractions chain correctly.

Multiplication, the register file, memory access and branching live elsewhere. The incoming flag vector comes from the status register, and the outgoing vector is written back to it.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add with carry, adding flag C) return the 8-bit sum. C is the carry out of bit 7, H is the carry out of bit 3, V is two's-complement overflow, N is result bit 7 and Z is set when the result is zero.
- R2: Opcode 2 (subtract) and opcode 3 (subtract with carry, also subtracting flag C) return the difference. C is the borrow out of bit 7, H is the borrow out of bit 3, V is signed overflow and N is bit 7.
- R3: For opcodes 3 and 5, Z is cleared when the result is nonzero and otherwise keeps its incoming value. For opcodes 0, 1, 2 and 4, Z reflects only the current result.
- R4: Opcode 4 (compare) and opcode 5 (compare with carry) set the flags exactly as opcodes 2 and 3 do, and they drive wr_en low.
- R5: Opcodes 6 (AND), 7 (OR) and 8 (XOR) write the bitwise result, set Z and N from it and clear V. C and H keep their incoming values.
- R6: Opcode 9 returns 0xFF minus the operand, sets C, clears V, sets Z and N from the result and keeps H.
- R7: Opcode 10 returns 0x00 minus the first operand, with C, H, V, N and Z as for a subtraction from zero.
- R8: Opcode 11 (increment) and opcode 12 (decrement) set V only on 0x7F to 0x80 and on 0x80 to 0x7F respectively. They set Z and N, and keep C and H.
- R9: Opcode 13 shifts left with 0 in and opcode 14 shifts right with 0 in. C takes the bit shifted out, V equals N XOR C, and H is kept.
- R10: Opcode 15 rotates left and opcode 16 rotates right through carry. The incoming C fills the vacated bit and the bit shifted out becomes C. V equals N XOR C.
- R11: Opcode 17 shifts right arithmetically: bit 7 stays, bits 7..1 move to bits 6..0 and bit 0 goes to C. V equals N XOR C.
- R12: Opcode 18 exchanges the two nibbles, writes the result and leaves all flags unchanged. Opcodes 19 to 31 drive wr_en low and leave all flags unchanged.
- R13: The flag vector layout is C in bit 0, Z in bit 1, N in bit 2, V in bit 3, S in bit 4 and H in bit 5. For opcodes 0 to 17, S equals N XOR V of the outgoing flags.
- R14: When use_imm is high, opcodes 0 to 8 take imm in place of op_b. When use_imm is low, op_b is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 5 | Operation select, codes as in the requirements |
| op_a | input | W | First operand, also the only operand of unary operations |
| op_b | input | W | Second register operand |
| imm | input | W | Immediate operand |
| use_imm | input | 1 | Select imm instead of op_b |
| flags_in | input | 6 | Current status flags {H,S,V,N,Z,C} |
| result | output | W | Computed result |
| wr_en | output | 1 | Result should be written back |
| flags_out | output | 6 | Next status flags {H,S,V,N,Z,C} |

## Verification
The hardest case is the sticky zero of the carry-chained subtract and compare. A wrong implementation only shows itself when the incoming Z is clear and the current byte's result is zero. The bench therefore drives flags_in directly, walking the carry-chained forms through all four combinations of incoming Z and zero or nonzero result, with the incoming carry both set and clear. A seeded sweep over every opcode, with random flag vectors, exposes any flag that is touched by an operation that should leave it alone.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADDC = 5'd1,
      OP_SUB  = 5'd2,
      OP_SUBC = 5'd3,
      OP_CMP  = 5'd4,
      OP_CMPC = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_INV  = 5'd9,
      OP_NEG  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_SHL  = 5'd13,
      OP_SHR  = 5'd14,
      OP_RCL  = 5'd15,
      OP_RCR  = 5'd16,
      OP_SAR  = 5'd17,
      OP_NSWP = 5'd18
   } alu_op_e;

   typedef struct packed {
      logic h;
      logic s;
      logic v;
      logic n;
      logic z;
      logic c;
   } alu_flags_t;

   localparam int FLAG_W = 6;

   function automatic logic is_sub_class(input alu_op_e op);
      return (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP) ||
             (op == OP_CMPC) || (op == OP_NEG);
   endfunction

   function automatic logic is_arith_class(input alu_op_e op);
      return (op == OP_ADD) || (op == OP_ADDC) || is_sub_class(op);
   endfunction

   function automatic logic takes_carry(input alu_op_e op);
      return (op == OP_ADDC) || (op == OP_SUBC) || (op == OP_CMPC);
   endfunction

   function automatic logic is_bitwise(input alu_op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
   endfunction

   function automatic logic is_shift_class(input alu_op_e op);
      return (op == OP_SHL) || (op == OP_SHR) || (op == OP_RCL) ||
             (op == OP_RCR) || (op == OP_SAR);
   endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W      = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         half,
   output logic         carry,
   output logic         ovf
);

   localparam int MSB = W - 1;

   logic [W-1:0] bx;
   logic         cx;
   logic         half_raw;
   logic         cout_raw;

   // subtraction as a + ~b + ~borrow_in; carries invert into borrows
   assign bx = sub ? ~b : b;
   assign cx = sub ? ~cin : cin;

   generate
      if (NIB < 1 || NIB >= W) begin : g_bad_nib
         $error("alu8_addsub: NIB must lie inside the word");
      end

      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = cx;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ bx[i] ^ cy[i];
            assign cy[i+1]  = (a[i] & bx[i]) | (cy[i] & (a[i] ^ bx[i]));
         end
         assign half_raw = cy[NIB];
         assign cout_raw = cy[W];
      end else begin : g_flat
         logic [W:0] full;
         assign full     = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
         assign sum      = full[W-1:0];
         // carry into bit NIB recovered from that bit's sum
         assign half_raw = a[NIB] ^ bx[NIB] ^ full[NIB];
         assign cout_raw = full[W];
      end
   endgenerate

   assign half  = half_raw ^ sub;
   assign carry = cout_raw ^ sub;
   assign ovf   = (a[MSB] == bx[MSB]) & (sum[MSB] != a[MSB]);

   always_comb begin
      if (!$isunknown({a, b, cin, sub})) begin
         // R1: an unsigned add without carry-in that carries out wraps below a
         if (!sub && !cin && carry)
            a_r1_wrap_below: assert (sum < a);
         // R2: subtracting zero with no borrow-in never borrows
         if (sub && !cin && (b == '0))
            a_r2_no_borrow: assert (!carry && !half);
      end
   end

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
   import alu8_pkg::*;
#(
   parameter int W   = 8,
   parameter int NIB = 4
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] r,
   output logic         c_out,
   output logic         v_step
);

   localparam int          MSB      = W - 1;
   localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAX_POS = ~MSB_ONLY;

   logic [W-1:0] swapped;

   generate
      if (2 * NIB == W) begin : g_half_swap
         assign swapped = {a[NIB-1:0], a[W-1:NIB]};
      end else begin : g_rot_swap
         // uneven widths: rotate the low NIB bits to the top
         assign swapped = (a >> NIB) | (a << (W - NIB));
      end
   endgenerate

   always_comb begin
      r      = a;
      c_out  = cin;
      v_step = 1'b0;
      unique case (op)
         OP_AND:  r = a & b;
         OP_OR:   r = a | b;
         OP_XOR:  r = a ^ b;
         OP_INV:  r = ~a;
         OP_INC: begin
            r      = a + ONE;
            v_step = (a == MAX_POS);
         end
         OP_DEC: begin
            r      = a - ONE;
            v_step = (a == MSB_ONLY);
         end
         OP_SHL: begin
            r     = {a[MSB-1:0], 1'b0};
            c_out = a[MSB];
         end
         OP_SHR: begin
            r     = {1'b0, a[MSB:1]};
            c_out = a[0];
         end
         OP_RCL: begin
            r     = {a[MSB-1:0], cin};
            c_out = a[MSB];
         end
         OP_RCR: begin
            r     = {cin, a[MSB:1]};
            c_out = a[0];
         end
         OP_SAR: begin
            r     = {a[MSB], a[MSB:1]};
            c_out = a[0];
         end
         OP_NSWP: r = swapped;
         default: r = a;
      endcase
   end

   always_comb begin
      if (!$isunknown({op, a})) begin
         // R11: arithmetic right shift keeps the sign bit
         if (op == OP_SAR)
            a_r11_sign_kept: assert (r[MSB] == a[MSB]);
         // R10: a rotate right places the old carry at the top
         if (op == OP_RCR && !$isunknown(cin))
            a_r10_carry_enters: assert (r[MSB] == cin);
      end
   end

endmodule

// File: rtl/alu8_flagmerge.sv
module alu8_flagmerge
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic         op_known,
   input  logic [W-1:0] as_sum,
   input  logic         as_half,
   input  logic         as_carry,
   input  logic         as_ovf,
   input  logic [W-1:0] un_r,
   input  logic         un_c,
   input  logic         un_v,
   input  alu_flags_t   f_in,
   output logic [W-1:0] res,
   output logic         wr,
   output alu_flags_t   f_out
);

   localparam int MSB = W - 1;

   logic zero;

   assign res  = is_arith_class(op) ? as_sum : un_r;
   assign zero = (res == '0);

   always_comb begin
      f_out = f_in;
      wr    = op_known && (op != OP_CMP) && (op != OP_CMPC);
      if (!op_known) begin
         f_out = f_in;
      end else if (is_arith_class(op)) begin
         f_out.h = as_half;
         f_out.c = as_carry;
         f_out.v = as_ovf;
         f_out.n = res[MSB];
         f_out.z = ((op == OP_SUBC) || (op == OP_CMPC)) ? (zero & f_in.z) : zero;
         f_out.s = as_ovf ^ res[MSB];
      end else if (is_bitwise(op)) begin
         f_out.v = 1'b0;
         f_out.n = res[MSB];
         f_out.z = zero;
         f_out.s = res[MSB];
      end else if (op == OP_INV) begin
         f_out.c = 1'b1;
         f_out.v = 1'b0;
         f_out.n = res[MSB];
         f_out.z = zero;
         f_out.s = res[MSB];
      end else if ((op == OP_INC) || (op == OP_DEC)) begin
         f_out.v = un_v;
         f_out.n = res[MSB];
         f_out.z = zero;
         f_out.s = un_v ^ res[MSB];
      end else if (is_shift_class(op)) begin
         f_out.c = un_c;
         f_out.v = res[MSB] ^ un_c;
         f_out.n = res[MSB];
         f_out.z = zero;
         f_out.s = un_c;
      end
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter int NIB    = 4,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [4:0]   opcode,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [W-1:0] imm,
   input  logic         use_imm,
   input  logic [5:0]   flags_in,
   output logic [W-1:0] result,
   output logic         wr_en,
   output logic [5:0]   flags_out
);

   localparam int LAST_OP = int'(OP_NSWP);

   generate
      if (W < 2) begin : g_bad_w
         $error("alu8_core: W must be at least 2");
      end
      if (FLAG_W != 6) begin : g_bad_flags
         $error("alu8_core: flag vector must be six bits");
      end
   endgenerate

   alu_op_e      op;
   logic         op_known;
   alu_flags_t   fin;
   alu_flags_t   fout;
   logic [W-1:0] opnd_b;
   logic [W-1:0] as_a;
   logic [W-1:0] as_b;
   logic         as_cin;
   logic [W-1:0] as_sum;
   logic         as_half;
   logic         as_carry;
   logic         as_ovf;
   logic [W-1:0] un_r;
   logic         un_c;
   logic         un_v;

   assign op       = alu_op_e'(opcode);
   assign op_known = (int'(opcode) <= LAST_OP);
   assign fin      = alu_flags_t'(flags_in);
   assign opnd_b   = use_imm ? imm : op_b;

   // negate runs through the subtractor as zero minus op_a
   assign as_a   = (op == OP_NEG) ? '0 : op_a;
   assign as_b   = (op == OP_NEG) ? op_a : opnd_b;
   assign as_cin = takes_carry(op) ? fin.c : 1'b0;

   alu8_addsub #(.W(W), .NIB(NIB), .RIPPLE(RIPPLE)) u_addsub (
      .a     (as_a),
      .b     (as_b),
      .cin   (as_cin),
      .sub   (is_sub_class(op)),
      .sum   (as_sum),
      .half  (as_half),
      .carry (as_carry),
      .ovf   (as_ovf)
   );

   alu8_unit #(.W(W), .NIB(NIB)) u_unit (
      .op     (op),
      .a      (op_a),
      .b      (opnd_b),
      .cin    (fin.c),
      .r      (un_r),
      .c_out  (un_c),
      .v_step (un_v)
   );

   alu8_flagmerge #(.W(W)) u_merge (
      .op       (op),
      .op_known (op_known),
      .as_sum   (as_sum),
      .as_half  (as_half),
      .as_carry (as_carry),
      .as_ovf   (as_ovf),
      .un_r     (un_r),
      .un_c     (un_c),
      .un_v     (un_v),
      .f_in     (fin),
      .res      (result),
      .wr       (wr_en),
      .f_out    (fout)
   );

   assign flags_out = fout;

   always_comb begin
      if (!$isunknown({opcode, op_a, op_b, imm, use_imm, flags_in})) begin
         // R13: signed test flag tracks negative xor overflow
         if (op_known && op != OP_NSWP)
            a_r13_sign_link: assert (fout.s == (fout.n ^ fout.v));
         // R4: compares never request a write
         if (op == OP_CMP || op == OP_CMPC)
            a_r4_cmp_no_write: assert (!wr_en);
         // R12: swap and unassigned codes leave every flag alone
         if (op == OP_NSWP || !op_known)
            a_r12_flags_held: assert (flags_out == flags_in);
         // R8: increment and decrement keep carry and half-carry
         if (op == OP_INC || op == OP_DEC)
            a_r8_carry_kept: assert (fout.c == fin.c && fout.h == fin.h);
         // R5: bitwise operations clear overflow
         if (is_bitwise(op))
            a_r5_v_cleared: assert (!fout.v && fout.c == fin.c);
         // R3: chained forms cannot set zero
         if ((op == OP_SUBC || op == OP_CMPC) && !fin.z)
            a_r3_z_sticky: assert (!fout.z);
      end
   end

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] opcode = '0;
   logic [7:0] op_a = '0, op_b = '0, imm = '0;
   logic       use_imm = 1'b0;
   logic [5:0] flags_in = '0;
   logic [7:0] result;
   logic       wr_en;
   logic [5:0] flags_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   alu8_core u0 (
      .opcode, .op_a, .op_b, .imm, .use_imm, .flags_in,
      .result, .wr_en, .flags_out
   );

   // independent reference: {wr, result, flags{H,S,V,N,Z,C}}
   function automatic logic [14:0] model(input logic [4:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] im,
                                         input logic ui, input logic [5:0] fi);
      logic [7:0] bb, r, x, y;
      logic [5:0] f;
      logic       wr;
      int         s, lo, k;
      bb = ui ? im : b;
      f  = fi;
      wr = 1'b1;
      r  = a;
      x  = a;
      y  = bb;
      k  = 0;
      case (op)
         5'd0, 5'd1: begin
            k    = (op == 5'd1) ? int'(fi[0]) : 0;
            s    = int'(a) + int'(bb) + k;
            lo   = int'(a[3:0]) + int'(bb[3:0]) + k;
            r    = s[7:0];
            f[0] = (s > 255);
            f[5] = (lo > 15);
            f[3] = (a[7] == bb[7]) && (r[7] != a[7]);
            f[2] = r[7];
            f[1] = (r == 8'h00);
         end
         5'd2, 5'd3, 5'd4, 5'd5, 5'd10: begin
            if (op == 5'd10) begin x = 8'h00; y = a; end
            k    = (op == 5'd3 || op == 5'd5) ? int'(fi[0]) : 0;
            s    = int'(x) - int'(y) - k;
            lo   = int'(x[3:0]) - int'(y[3:0]) - k;
            r    = s[7:0];
            f[0] = (s < 0);
            f[5] = (lo < 0);
            f[3] = (x[7] != y[7]) && (r[7] != x[7]);
            f[2] = r[7];
            f[1] = (r == 8'h00) && ((op == 5'd3 || op == 5'd5) ? fi[1] : 1'b1);
            wr   = !(op == 5'd4 || op == 5'd5);
         end
         5'd6:  begin r = a & bb; f[3] = 1'b0; end
         5'd7:  begin r = a | bb; f[3] = 1'b0; end
         5'd8:  begin r = a ^ bb; f[3] = 1'b0; end
         5'd9:  begin r = 8'hFF - a; f[0] = 1'b1; f[3] = 1'b0; end
         5'd11: begin r = a + 8'd1; f[3] = (a == 8'h7F); end
         5'd12: begin r = a - 8'd1; f[3] = (a == 8'h80); end
         5'd13: begin r = a << 1; f[0] = a[7]; end
         5'd14: begin r = a >> 1; f[0] = a[0]; end
         5'd15: begin r = {a[6:0], fi[0]}; f[0] = a[7]; end
         5'd16: begin r = {fi[0], a[7:1]}; f[0] = a[0]; end
         5'd17: begin r = {a[7], a[7:1]}; f[0] = a[0]; end
         5'd18: r = {a[3:0], a[7:4]};
         default: wr = 1'b0;
      endcase
      if (op >= 5'd6 && op <= 5'd17 && op != 5'd10) begin
         f[2] = r[7];
         f[1] = (r == 8'h00);
      end
      if (op >= 5'd13 && op <= 5'd17) f[3] = r[7] ^ f[0];
      if (op <= 5'd17) f[4] = f[2] ^ f[3];
      return {wr, r, f};
   endfunction

   task automatic chk(input string tag, input logic [4:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] im, input logic ui,
                      input logic [5:0] fi);
      logic [14:0] exp;
      @(posedge clk);
      #2;
      opcode = op; op_a = a; op_b = b; imm = im; use_imm = ui; flags_in = fi;
      #5;
      exp = model(op, a, b, im, ui, fi);
      n_run++;
      if (wr_en !== exp[14] || flags_out !== exp[5:0] ||
          (exp[14] && result !== exp[13:6])) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b fi=%b: got wr=%0b r=%h f=%b, expected wr=%0b r=%h f=%b",
                  tag, op, a, b, im, ui, fi, wr_en, result, flags_out,
                  exp[14], exp[13:6], exp[5:0]);
      end
   endtask

   task automatic t_idle;
      // R1: all-zero inputs give a zero sum with only Z set
      chk("R1", 5'd0, 8'h00, 8'h00, 8'h00, 1'b0, 6'b000000);
   endtask

   task automatic t_add;
      chk("R1", 5'd0, 8'h08, 8'h08, 8'h00, 1'b0, 6'b000000);
      chk("R1", 5'd0, 8'h7F, 8'h01, 8'h00, 1'b0, 6'b000000);
      chk("R1", 5'd0, 8'hFF, 8'h01, 8'h00, 1'b0, 6'b000000);
      chk("R1", 5'd1, 8'h0F, 8'h00, 8'h00, 1'b0, 6'b000001);
      chk("R1", 5'd1, 8'h80, 8'h80, 8'h00, 1'b0, 6'b000001);
      chk("R14", 5'd0, 8'h10, 8'hEE, 8'h22, 1'b1, 6'b000000);
      chk("R14", 5'd0, 8'h10, 8'hEE, 8'h22, 1'b0, 6'b000000);
      chk("R14", 5'd6, 8'hF0, 8'h0F, 8'h3C, 1'b1, 6'b000000);
   endtask

   task automatic t_sub;
      chk("R2", 5'd2, 8'h10, 8'h01, 8'h00, 1'b0, 6'b000000);
      chk("R2", 5'd2, 8'h00, 8'h01, 8'h00, 1'b0, 6'b000000);
      chk("R2", 5'd2, 8'h80, 8'h01, 8'h00, 1'b0, 6'b000000);
      chk("R2", 5'd3, 8'h05, 8'h05, 8'h00, 1'b0, 6'b000011);
      chk("R2", 5'd2, 8'h33, 8'h00, 8'h34, 1'b1, 6'b000000);
   endtask

   task automatic t_chain_z;
      // R3: every mix of incoming Z, carry and zero/nonzero result
      for (int zc = 0; zc < 4; zc++) begin
         logic [5:0] fi;
         fi = {4'b0000, zc[1], zc[0]};
         chk("R3", 5'd3, 8'h20, 8'h20 - {7'd0, zc[0]}, 8'h00, 1'b0, fi);
         chk("R3", 5'd3, 8'h20, 8'h10, 8'h00, 1'b0, fi);
         chk("R3", 5'd5, 8'h44, 8'h44 - {7'd0, zc[0]}, 8'h00, 1'b0, fi);
         chk("R3", 5'd5, 8'h44, 8'h45, 8'h00, 1'b0, fi);
      end
      chk("R3", 5'd2, 8'h09, 8'h09, 8'h00, 1'b0, 6'b000000);
   endtask

   task automatic t_cmp;
      chk("R4", 5'd4, 8'h12, 8'h12, 8'h00, 1'b0, 6'b000000);
      chk("R4", 5'd4, 8'h01, 8'h02, 8'h00, 1'b0, 6'b100110);
      chk("R4", 5'd5, 8'h7F, 8'h80, 8'h00, 1'b0, 6'b000001);
      chk("R4", 5'd4, 8'h40, 8'h00, 8'h41, 1'b1, 6'b000000);
   endtask

   task automatic t_logic;
      chk("R5", 5'd6, 8'hAA, 8'h55, 8'h00, 1'b0, 6'b101001);
      chk("R5", 5'd7, 8'h80, 8'h01, 8'h00, 1'b0, 6'b001000);
      chk("R5", 5'd8, 8'h5A, 8'h5A, 8'h00, 1'b0, 6'b100001);
   endtask

   task automatic t_com_neg;
      chk("R6", 5'd9, 8'hFF, 8'h00, 8'h00, 1'b0, 6'b101000);
      chk("R6", 5'd9, 8'h12, 8'h00, 8'h00, 1'b0, 6'b000000);
      chk("R7", 5'd10, 8'h00, 8'h00, 8'h00, 1'b0, 6'b111111);
      chk("R7", 5'd10, 8'h80, 8'h00, 8'h00, 1'b0, 6'b000000);
      chk("R7", 5'd10, 8'h01, 8'h00, 8'h00, 1'b0, 6'b000000);
      chk("R7", 5'd10, 8'h10, 8'h00, 8'h00, 1'b0, 6'b000000);
   endtask

   task automatic t_incdec;
      chk("R8", 5'd11, 8'h7F, 8'h00, 8'h00, 1'b0, 6'b100001);
      chk("R8", 5'd11, 8'hFF, 8'h00, 8'h00, 1'b0, 6'b000000);
      chk("R8", 5'd12, 8'h80, 8'h00, 8'h00, 1'b0, 6'b000001);
      chk("R8", 5'd12, 8'h01, 8'h00, 8'h00, 1'b0, 6'b100000);
   endtask

   task automatic t_shift;
      chk("R9", 5'd13, 8'hC0, 8'h00, 8'h00, 1'b0, 6'b100000);
      chk("R9", 5'd13, 8'h40, 8'h00, 8'h00, 1'b0, 6'b000001);
      chk("R9", 5'd14, 8'h01, 8'h00, 8'h00, 1'b0, 6'b100000);
      chk("R10", 5'd15, 8'h80, 8'h00, 8'h00, 1'b0, 6'b000001);
      chk("R10", 5'd15, 8'h01, 8'h00, 8'h00, 1'b0, 6'b000000);
      chk("R10", 5'd16, 8'h01, 8'h00, 8'h00, 1'b0, 6'b000001);
      chk("R10", 5'd16, 8'h02, 8'h00, 8'h00, 1'b0, 6'b000000);
      chk("R11", 5'd17, 8'h81, 8'h00, 8'h00, 1'b0, 6'b000000);
      chk("R11", 5'd17, 8'h7E, 8'h00, 8'h00, 1'b0, 6'b000001);
   endtask

   task automatic t_swap_other;
      chk("R12", 5'd18, 8'hA5, 8'h00, 8'h00, 1'b0, 6'b101010);
      chk("R12", 5'd18, 8'h00, 8'h00, 8'h00, 1'b0, 6'b010101);
      chk("R12", 5'd25, 8'h33, 8'h44, 8'h00, 1'b0, 6'b110011);
      chk("R12", 5'd31, 8'hFF, 8'hFF, 8'h00, 1'b1, 6'b001100);
   endtask

   task automatic t_sweep;
      // R13: seeded sweep over every opcode with random flags
      logic [31:0] seed;
      seed = 32'h1234_5678;
      for (int i = 0; i < 600; i++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         chk("R13", 5'(i % 20 == 19 ? 23 : i % 20), seed[7:0], seed[15:8],
             seed[23:16], seed[24], seed[30:25]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_add();
      t_sub();
      t_chain_z();
      t_cmp();
      t_logic();
      t_com_neg();
      t_incdec();
      t_shift();
      t_swap_other();
      t_sweep();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule